// File: doc/BRIEF.md
# Mailbox Command Sequencer With Timeout

This block sits on the host side of a doorbell mailbox and runs commands through it strictly one after another. It takes the command at the head of an external request queue and stamps a rolling sequence number and a forced acknowledge-request flag into the header. It then writes the header and three data words into the four outbound mailbox registers and rings the controller doorbell. After that it watches the host doorbell for the controller's replies.

A command finishes on one of four events. The first is an acknowledge, when the caller asked for no response. The second is a response, whose own sequence number must match. The third is a send failure reported by the register path. The fourth is expiry of a per-command deadline taken from a free-running timer. A back-from-reset notification abandons the current attempt and sends the same command again under the same sequence number. Every completion pops the queue head and reports a 16-bit status: the response's primary status on a good response, and fixed codes for generic and sequence errors.

Top module: `mbox_seq`

## Requirements
- R1: At most one command is outstanding: after a doorbell ring, no mailbox write occurs until that command completes or a back-from-reset notification is handled.
- R2: Mailbox word 0 carries the command in bits 15:0, the sequence number in bits 31:16, and in bits 47:32 the caller flags OR 0x0100 (acknowledge request, always) OR 0x0200 (only when a response is required). Bits 63:48 are zero. Words 1 to 3 carry the three data words unchanged.
- R3: The four mailbox writes use index 0, 1, 2, 3 on consecutive cycles, and the controller doorbell ring pulse follows in the cycle after index 3.
- R4: The sequence number is 1 after reset and advances once per newly issued command, including one whose send fails. When it would reach all ones (2^SEQ_W-1) it becomes 1, so it is never 0. A command re-sent after a reset notification keeps its number, and done_seq_o reports the completing command's number.
- R5: An acknowledge (host doorbell bit 0) while waiting is cleared by an AND write that drops only bit 0. If no response is required, completion with status 0x0000 and a queue pop happen in that same cycle; otherwise the sequencer keeps waiting.
- R6: A response-waiting indication (bit 1) while waiting causes four response reads, index 0 to 3, on consecutive cycles. In the next cycle, an AND write drops only bit 1 and the command completes. Its status is response word 0 bits 63:48 when word 0 bits 31:16 equal the command's sequence number, else 0x00FD.
- R7: When acknowledge and response bits are both set, the acknowledge is cleared first and the response is read only afterwards.
- R8: A back-from-reset indication (bit 2) has top priority. It clears all doorbell bits with one AND write, produces no completion, and causes the same command to be sent again.
- R9: The deadline is the timer value in the ring cycle plus TIMEOUT. In the first cycle the timer is past it (wrap-safe compare) with no doorbell bit set, the command completes with 0x00FE, and the next queued command is then issued.
- R10: A send failure (mb_err_i during a mailbox write or the ring) completes the command with 0x00FE in that cycle. After four consecutive failures, no command is issued until a non-zero host doorbell is read while idle.
- R11: While idle, a response bit with nothing outstanding is cleared with no response read and no completion. Any bit at position 3 or above clears all bits and has no other effect.
- R12: During reset no write, ring, read, clear, pop or completion strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Queue head holds a command |
| req_cmd_i | input | 16 | Command class and subclass |
| req_flags_i | input | 16 | Caller control flags |
| req_resp_i | input | 1 | Command requires a response |
| req_w1_i | input | 64 | Data word 1 |
| req_w2_i | input | 64 | Data word 2 |
| req_w3_i | input | 64 | Data word 3 |
| req_pop_o | output | 1 | Remove the queue head |
| mb_we_o | output | 1 | Outbound mailbox write strobe |
| mb_idx_o | output | 2 | Outbound mailbox register index |
| mb_wdata_o | output | 64 | Outbound mailbox write data |
| mb_err_i | input | 1 | Current write or ring failed |
| ring_o | output | 1 | Set message-waiting in the controller doorbell |
| hdb_i | input | DB_W | Host doorbell value |
| hdb_clr_o | output | 1 | AND write to the host doorbell |
| hdb_keep_o | output | DB_W | AND mask (bits kept) |
| rsp_rd_o | output | 1 | Response register read strobe |
| rsp_idx_o | output | 2 | Response register index |
| rsp_data_i | input | 64 | Response read data, same cycle |
| timer_i | input | TM_W | Free-running timer |
| done_o | output | 1 | Command completion strobe |
| done_status_o | output | 16 | Completion status |
| done_seq_o | output | 16 | Sequence number of the completed command |

## Verification
A wrong sequence counter or a lost in-flight marker shows up in the header at the very next ring, in the same cycle that the bench compares word 0 with its own sequence model. A wrong event order is visible within one cycle of the doorbell bits arriving, as the AND mask and the response-read strobes. A bad deadline moves the timeout completion away from exactly TIMEOUT+1 cycles after the ring. A lost stall or failure count shows as extra mailbox writes or a wrong number of completions within a few cycles of a failure burst.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = 16;

  localparam logic [HALF_W-1:0] FLAG_ACK  = 16'h0100;
  localparam logic [HALF_W-1:0] FLAG_RESP = 16'h0200;

  localparam logic [HALF_W-1:0] STAT_OK  = 16'h0000;
  localparam logic [HALF_W-1:0] STAT_GEN = 16'h00FE;
  localparam logic [HALF_W-1:0] STAT_SEQ = 16'h00FD;

  localparam int unsigned DB_ACK  = 0;
  localparam int unsigned DB_RESP = 1;
  localparam int unsigned DB_RST  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_RING, S_WAIT, S_READ, S_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_RST, EV_ACK, EV_RESP, EV_OTHER
  } db_ev_e;
endpackage

// File: rtl/mbox_seqnum.sv
module mbox_seqnum #(
  parameter int unsigned SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEQ_W-1:0] seq_o
);
  localparam logic [SEQ_W-1:0] SEQ_FIRST = SEQ_W'(1);

  logic [SEQ_W-1:0] nxt;

  always_comb begin
    nxt = seq_o + SEQ_FIRST;
    if (nxt == '1) nxt = SEQ_FIRST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seq_o <= SEQ_FIRST;
    else if (adv_i) seq_o <= nxt;
  end

  p_seq_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_o != '0) && (seq_o != '1));
endmodule

// File: rtl/mbox_deadline.sv
module mbox_deadline #(
  parameter int unsigned TM_W    = 32,
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TM_W-1:0] now_i,
  output logic            expired_o
);
  localparam logic [TM_W-1:0] SPAN = TM_W'(TIMEOUT);

  logic [TM_W-1:0] dl_q;
  logic [TM_W-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dl_q <= '0;
    else if (load_i) dl_q <= now_i + SPAN;
  end

  // strictly later than the deadline, modulo timer wrap
  assign diff      = now_i - dl_q;
  assign expired_o = !diff[TM_W-1] && (diff != '0);
endmodule

// File: rtl/mbox_dbell_dec.sv
module mbox_dbell_dec
  import mbox_pkg::*;
#(
  parameter int unsigned DB_W = 8
) (
  input  logic [DB_W-1:0] hdb_i,
  output db_ev_e          ev_o
);
  logic [DB_W-1:0] known;

  always_comb begin
    known          = '0;
    known[DB_ACK]  = 1'b1;
    known[DB_RESP] = 1'b1;
    known[DB_RST]  = 1'b1;
    if (hdb_i[DB_RST])             ev_o = EV_RST;
    else if (hdb_i[DB_ACK])        ev_o = EV_ACK;
    else if (hdb_i[DB_RESP])       ev_o = EV_RESP;
    else if (|(hdb_i & ~known))    ev_o = EV_OTHER;
    else                           ev_o = EV_NONE;
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned DB_W    = 8,
  parameter int unsigned TM_W    = 32,
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [15:0]       req_cmd_i,
  input  logic [15:0]       req_flags_i,
  input  logic              req_resp_i,
  input  logic [63:0]       req_w1_i,
  input  logic [63:0]       req_w2_i,
  input  logic [63:0]       req_w3_i,
  output logic              req_pop_o,
  output logic              mb_we_o,
  output logic [1:0]        mb_idx_o,
  output logic [63:0]       mb_wdata_o,
  input  logic              mb_err_i,
  output logic              ring_o,
  input  logic [DB_W-1:0]   hdb_i,
  output logic              hdb_clr_o,
  output logic [DB_W-1:0]   hdb_keep_o,
  output logic              rsp_rd_o,
  output logic [1:0]        rsp_idx_o,
  input  logic [63:0]       rsp_data_i,
  input  logic [TM_W-1:0]   timer_i,
  output logic              done_o,
  output logic [15:0]       done_status_o,
  output logic [15:0]       done_seq_o
);
  localparam int unsigned IDX_W    = 2;
  localparam logic [IDX_W-1:0] IDX_LAST = '1;
  localparam int unsigned FAIL_W   = 2;
  localparam logic [FAIL_W-1:0] FAIL_LAST = '1;

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              inflight_q, inflight_d;
  logic              stall_q, stall_d;
  logic [FAIL_W-1:0] fail_q, fail_d;
  logic [SEQ_W-1:0]  cmd_seq_q, cmd_seq_d;
  logic [15:0]       rsp_stat_q, rsp_stat_d;
  logic [15:0]       rsp_seq_q, rsp_seq_d;

  logic              seq_adv, dl_load, expired, fin;
  logic [15:0]       fin_stat;
  logic [SEQ_W-1:0]  seq_now;
  logic [15:0]       hdr_flags;
  db_ev_e            ev;
  logic              unused_rsp;

  assign unused_rsp = ^{rsp_data_i[47:32], rsp_data_i[15:0]};

  mbox_seqnum #(.SEQ_W(SEQ_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(seq_adv), .seq_o(seq_now)
  );

  mbox_deadline #(.TM_W(TM_W), .TIMEOUT(TIMEOUT)) u_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dl_load), .now_i(timer_i), .expired_o(expired)
  );

  mbox_dbell_dec #(.DB_W(DB_W)) u_dec (.hdb_i(hdb_i), .ev_o(ev));

  assign hdr_flags  = req_flags_i | FLAG_ACK | (req_resp_i ? FLAG_RESP : 16'h0000);
  assign done_seq_o = 16'(cmd_seq_q);

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    inflight_d = inflight_q;
    stall_d    = stall_q;
    fail_d     = fail_q;
    cmd_seq_d  = cmd_seq_q;
    rsp_stat_d = rsp_stat_q;
    rsp_seq_d  = rsp_seq_q;
    seq_adv    = 1'b0;
    dl_load    = 1'b0;
    fin        = 1'b0;
    fin_stat   = STAT_OK;
    mb_we_o    = 1'b0;
    mb_idx_o   = idx_q;
    mb_wdata_o = '0;
    ring_o     = 1'b0;
    hdb_clr_o  = 1'b0;
    hdb_keep_o = '1;
    rsp_rd_o   = 1'b0;
    rsp_idx_o  = idx_q;

    unique case (state_q)
      S_IDLE: begin
        if (ev != EV_NONE) begin
          hdb_clr_o = 1'b1;
          stall_d   = 1'b0;
          fail_d    = '0;
          if (ev == EV_ACK)       hdb_keep_o[DB_ACK]  = 1'b0;
          else if (ev == EV_RESP) hdb_keep_o[DB_RESP] = 1'b0;
          else                    hdb_keep_o          = '0;
        end else if (req_valid_i && !stall_q) begin
          state_d = S_SEND;
          idx_d   = '0;
          if (!inflight_q) begin
            seq_adv    = 1'b1;
            cmd_seq_d  = seq_now;
            inflight_d = 1'b1;
          end
        end
      end
      S_SEND: begin
        mb_we_o = 1'b1;
        unique case (idx_q)
          2'd0:    mb_wdata_o = {16'h0000, hdr_flags, 16'(cmd_seq_q), req_cmd_i};
          2'd1:    mb_wdata_o = req_w1_i;
          2'd2:    mb_wdata_o = req_w2_i;
          default: mb_wdata_o = req_w3_i;
        endcase
        if (mb_err_i) begin
          fin = 1'b1;
          fin_stat = STAT_GEN;
        end else if (idx_q == IDX_LAST) state_d = S_RING;
        else idx_d = idx_q + 1'b1;
      end
      S_RING: begin
        ring_o = 1'b1;
        if (mb_err_i) begin
          fin = 1'b1;
          fin_stat = STAT_GEN;
        end else begin
          dl_load = 1'b1;
          fail_d  = '0;
          state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        unique case (ev)
          EV_RST: begin
            hdb_clr_o  = 1'b1;
            hdb_keep_o = '0;
            state_d    = S_IDLE;   // command stays in flight and is re-sent
          end
          EV_ACK: begin
            hdb_clr_o          = 1'b1;
            hdb_keep_o[DB_ACK] = 1'b0;
            if (!req_resp_i) fin = 1'b1;
          end
          EV_RESP: begin
            state_d = S_READ;
            idx_d   = '0;
          end
          EV_OTHER: begin
            hdb_clr_o  = 1'b1;
            hdb_keep_o = '0;
          end
          default: begin
            if (expired) begin
              fin = 1'b1;
              fin_stat = STAT_GEN;
            end
          end
        endcase
      end
      S_READ: begin
        rsp_rd_o = 1'b1;
        if (idx_q == '0) begin
          rsp_stat_d = rsp_data_i[63:48];
          rsp_seq_d  = rsp_data_i[31:16];
        end
        if (idx_q == IDX_LAST) state_d = S_FIN;
        else idx_d = idx_q + 1'b1;
      end
      default: begin
        hdb_clr_o           = 1'b1;
        hdb_keep_o[DB_RESP] = 1'b0;
        fin      = 1'b1;
        fin_stat = (rsp_seq_q == 16'(cmd_seq_q)) ? rsp_stat_q : STAT_SEQ;
      end
    endcase

    if (fin) begin
      state_d    = S_IDLE;
      inflight_d = 1'b0;
      if ((state_q == S_SEND) || (state_q == S_RING)) begin
        if (fail_q == FAIL_LAST) begin
          stall_d = 1'b1;
          fail_d  = '0;
        end else begin
          fail_d = fail_q + 1'b1;
        end
      end
    end
  end

  assign done_o        = fin;
  assign req_pop_o     = fin;
  assign done_status_o = fin_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      inflight_q <= 1'b0;
      stall_q    <= 1'b0;
      fail_q     <= '0;
      cmd_seq_q  <= '0;
      rsp_stat_q <= '0;
      rsp_seq_q  <= '0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      inflight_q <= inflight_d;
      stall_q    <= stall_d;
      fail_q     <= fail_d;
      cmd_seq_q  <= cmd_seq_d;
      rsp_stat_q <= rsp_stat_d;
      rsp_seq_q  <= rsp_seq_d;
    end
  end

  p_ring_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_o |-> $past(mb_we_o && (mb_idx_o == IDX_LAST)));

  p_rsp_then_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_rd_o && (rsp_idx_o == IDX_LAST)) |=> (hdb_clr_o && !hdb_keep_o[DB_RESP] && done_o));

  p_ack_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_WAIT) && hdb_i[DB_ACK] && !hdb_i[DB_RST])
      |-> (hdb_clr_o && !hdb_keep_o[DB_ACK] && hdb_keep_o[DB_RESP]));

  p_reset_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((state_q == S_IDLE) || (state_q == S_WAIT)) && hdb_i[DB_RST])
      |-> (hdb_clr_o && (hdb_keep_o == '0) && !done_o));

  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |-> !mb_we_o);
endmodule

// File: tb/mbox_seq_test.sv
module mbox_seq_test;
  import mbox_pkg::*;

  localparam int SEQ_W = 4;
  localparam int DB_W  = 8;
  localparam int TM_W  = 32;
  localparam int TMO   = 40;
  localparam int QN    = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] q_cmd [QN];
  logic [15:0] q_flg [QN];
  logic        q_rsp [QN];
  logic [63:0] q_w1 [QN];
  logic [63:0] q_w2 [QN];
  logic [63:0] q_w3 [QN];
  int head = 0;
  int tail = 0;

  logic        req_valid, req_pop, mb_we, mb_err, ring, hdb_clr, rsp_rd, done;
  logic [1:0]  mb_idx, rsp_idx;
  logic [63:0] mb_wdata, rsp_data;
  logic [7:0]  hdb, hdb_set, hdb_keep;
  logic [15:0] done_status, done_seq;
  logic [63:0] rsp_mem [4];

  assign req_valid = head < tail;
  assign rsp_data  = rsp_mem[rsp_idx];

  mbox_seq #(.SEQ_W(SEQ_W), .DB_W(DB_W), .TM_W(TM_W), .TIMEOUT(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_cmd_i(q_cmd[head % QN]), .req_flags_i(q_flg[head % QN]),
    .req_resp_i(q_rsp[head % QN]), .req_w1_i(q_w1[head % QN]), .req_w2_i(q_w2[head % QN]),
    .req_w3_i(q_w3[head % QN]), .req_pop_o(req_pop),
    .mb_we_o(mb_we), .mb_idx_o(mb_idx), .mb_wdata_o(mb_wdata), .mb_err_i(mb_err),
    .ring_o(ring), .hdb_i(hdb), .hdb_clr_o(hdb_clr), .hdb_keep_o(hdb_keep),
    .rsp_rd_o(rsp_rd), .rsp_idx_o(rsp_idx), .rsp_data_i(rsp_data),
    .timer_i(TM_W'(cyc)),
    .done_o(done), .done_status_o(done_status), .done_seq_o(done_seq)
  );

  always @(posedge clk) if (req_pop) head <= head + 1;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) hdb <= '0;
    else        hdb <= (hdb_clr ? (hdb & hdb_keep) : hdb) | hdb_set;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int nxt_seq(input int s);
    int n = s + 1;
    if (n == (1 << SEQ_W) - 1) n = 1;
    return n;
  endfunction

  // monitor state
  logic [63:0] mbw [4];
  int exp_seq = 1, cur_exp = 0, seq_head = -1;
  int wr_cnt = 0, ring_cnt = 0, done_cnt = 0, rd_cnt = 0;
  int ring_cyc = 0, done_cyc = 0, prev_w_cyc = 0, prev_idx = 0;
  int ack_clr_cyc = -1, rd_first_cyc = -1;
  int r1_viol = 0;
  bit outstanding = 0;
  logic [15:0] last_st, last_seq, ring_seq;

  always @(negedge clk) if (rst_n) begin
    if (mb_we) begin
      wr_cnt++;
      if (outstanding) r1_viol++;
      if (mb_idx != 2'd0)
        chk((int'(mb_idx) == prev_idx + 1) && (cyc == prev_w_cyc + 1), "R3 write order",
            64'(mb_idx), 64'(prev_idx + 1));
      prev_idx = int'(mb_idx);
      prev_w_cyc = cyc;
      mbw[mb_idx] = mb_wdata;
      if (mb_idx == 2'd0 && head != seq_head) begin
        seq_head = head;
        cur_exp  = exp_seq;
        exp_seq  = nxt_seq(exp_seq);
      end
    end
    if (ring) begin
      logic [15:0] fl;
      ring_cnt++;
      ring_cyc = cyc;
      outstanding = 1;
      ring_seq = mbw[0][31:16];
      fl = q_flg[head % QN] | 16'h0100 | (q_rsp[head % QN] ? 16'h0200 : 16'h0000);
      chk(prev_idx == 3 && cyc == prev_w_cyc + 1, "R3 ring after word 3", 64'(cyc), 64'(prev_w_cyc + 1));
      chk(mbw[0] == {16'h0, fl, 16'(cur_exp), q_cmd[head % QN]}, "R2 R4 header",
          mbw[0], {16'h0, fl, 16'(cur_exp), q_cmd[head % QN]});
      chk(mbw[1] == q_w1[head % QN] && mbw[2] == q_w2[head % QN] && mbw[3] == q_w3[head % QN],
          "R2 data words", mbw[3], q_w3[head % QN]);
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
      last_st  = done_status;
      last_seq = done_seq;
      outstanding = 0;
    end
    if (rsp_rd) begin
      rd_cnt++;
      if (rd_first_cyc < 0) rd_first_cyc = cyc;
    end
    if (hdb_clr && !hdb_keep[0] && hdb_keep[1]) ack_clr_cyc = cyc;
    if (hdb_clr && hdb_keep == '0) outstanding = 0;
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic push(input logic [15:0] c, input logic [15:0] f, input logic r,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    q_cmd[tail % QN] = c; q_flg[tail % QN] = f; q_rsp[tail % QN] = r;
    q_w1[tail % QN] = a;  q_w2[tail % QN] = b;  q_w3[tail % QN] = d;
    tail++;
  endtask

  task automatic pulse_db(input logic [7:0] bits);
    hdb_set = bits;
    tick(1);
    hdb_set = '0;
  endtask

  task automatic wait_ring(input int n, input string r);
    int k = 0;
    while (ring_cnt < n && k < 300) begin tick(1); k++; end
    chk(ring_cnt >= n, r, 64'(ring_cnt), 64'(n));
  endtask

  task automatic wait_done(input int n, input string r);
    int k = 0;
    while (done_cnt < n && k < 300) begin tick(1); k++; end
    chk(done_cnt >= n, r, 64'(done_cnt), 64'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rb, nr, nd, s;
    s = $urandom(32'h5EED);
    hdb_set = '0;
    mb_err  = 1'b0;
    for (int i = 0; i < 4; i++) rsp_mem[i] = '0;
    tick(3);
    // R12
    chk(!mb_we && !ring && !rsp_rd && !hdb_clr && !req_pop && !done, "R12 reset outputs",
        {58'h0, mb_we, ring, rsp_rd, hdb_clr, req_pop, done}, 64'h0);
    rst_n = 1'b1;
    tick(2);

    // no-response command, acknowledged
    push(16'h0A01, 16'h0004, 1'b0, 64'h1111, 64'h2222, 64'h3333);
    wait_ring(1, "R2 first ring");
    tick(2);
    chk(done_cnt == 0, "R5 no completion before ack", 64'(done_cnt), 64'h0);
    pulse_db(8'h01);
    wait_done(1, "R5 ack completion");
    chk(last_st == STAT_OK, "R5 status", 64'(last_st), 64'(STAT_OK));
    chk(last_seq == 16'd1, "R4 first sequence", 64'(last_seq), 64'd1);
    tick(1);
    chk(hdb == 8'h00, "R5 ack bit cleared", 64'(hdb), 64'h0);

    // response-required command, good response
    push(16'h0B02, 16'h0000, 1'b1, 64'hAAAA, 64'hBBBB, 64'hCCCC);
    wait_ring(2, "R2 second ring");
    pulse_db(8'h01);
    tick(5);
    chk(done_cnt == 1, "R5 waits for response", 64'(done_cnt), 64'd1);
    rsp_mem[0] = {16'h1234, 16'h0000, 16'd2, 16'h0000};
    rb = rd_cnt;
    pulse_db(8'h02);
    wait_done(2, "R6 response completion");
    chk(last_st == 16'h1234, "R6 primary status", 64'(last_st), 64'h1234);
    chk(rd_cnt - rb == 4, "R6 four reads", 64'(rd_cnt - rb), 64'd4);

    // ack and response together, sequence mismatch
    push(16'h0C03, 16'h0010, 1'b1, 64'h1, 64'h2, 64'h3);
    wait_ring(3, "R2 third ring");
    rsp_mem[0] = {16'h5555, 16'h0000, 16'd7, 16'h0000};
    rd_first_cyc = -1;
    ack_clr_cyc = -1;
    pulse_db(8'h03);
    wait_done(3, "R6 mismatch completion");
    chk(last_st == STAT_SEQ, "R6 sequence error", 64'(last_st), 64'(STAT_SEQ));
    chk(ack_clr_cyc >= 0 && ack_clr_cyc < rd_first_cyc, "R7 ack before response",
        64'(ack_clr_cyc), 64'(rd_first_cyc));

    // timeout, then the next queued command goes out
    push(16'h0D04, 16'h0000, 1'b0, 64'h4, 64'h5, 64'h6);
    push(16'h0E05, 16'h0000, 1'b0, 64'h7, 64'h8, 64'h9);
    wait_ring(4, "R9 ring before timeout");
    wait_done(4, "R9 timeout completion");
    chk(last_st == STAT_GEN, "R9 timeout status", 64'(last_st), 64'(STAT_GEN));
    chk(done_cyc - ring_cyc == TMO + 1, "R9 timeout cycle", 64'(done_cyc - ring_cyc), 64'(TMO + 1));
    wait_ring(5, "R9 next command issued");
    pulse_db(8'h01);
    wait_done(5, "R5 completion after timeout");

    // back-from-reset with ack also set: resend with same number
    push(16'h0F06, 16'h0000, 1'b0, 64'hD1, 64'hD2, 64'hD3);
    wait_ring(6, "R8 first send");
    chk(ring_seq == 16'd6, "R4 sequence six", 64'(ring_seq), 64'd6);
    pulse_db(8'h05);
    wait_ring(7, "R8 resend");
    chk(done_cnt == 5, "R8 no completion on reset", 64'(done_cnt), 64'd5);
    chk(ring_seq == 16'd6, "R8 same sequence", 64'(ring_seq), 64'd6);
    pulse_db(8'h01);
    wait_done(6, "R8 completion after resend");
    chk(last_st == STAT_OK && last_seq == 16'd6, "R8 status", 64'(last_seq), 64'd6);

    // stray response and unknown bit while idle
    rb = rd_cnt;
    pulse_db(8'h22);
    tick(3);
    chk(hdb == 8'h00, "R11 bits cleared", 64'(hdb), 64'h0);
    chk(done_cnt == 6, "R11 no completion", 64'(done_cnt), 64'd6);
    chk(rd_cnt == rb, "R11 no response read", 64'(rd_cnt), 64'(rb));

    // send failures and stall
    mb_err = 1'b1;
    for (int i = 0; i < 6; i++) push(16'h1000 + 16'(i), 16'h0, 1'b0, 64'(i), 64'h0, 64'h0);
    tick(20);
    chk(done_cnt == 10, "R10 four failures", 64'(done_cnt), 64'd10);
    chk(last_st == STAT_GEN, "R10 failure status", 64'(last_st), 64'(STAT_GEN));
    chk(tail - head == 2, "R10 two left queued", 64'(tail - head), 64'd2);
    rb = wr_cnt;
    tick(10);
    chk(wr_cnt == rb, "R10 stalled", 64'(wr_cnt), 64'(rb));
    mb_err = 1'b0;
    pulse_db(8'h10);
    wait_ring(8, "R10 resume after doorbell");
    chk(ring_seq == 16'd11, "R4 failures consume numbers", 64'(ring_seq), 64'd11);
    pulse_db(8'h01);
    wait_done(11, "R10 resumed completion");
    wait_ring(9, "R10 last queued");
    pulse_db(8'h01);
    wait_done(12, "R10 last completion");

    // random traffic, crosses the sequence wrap (R4)
    nr = 9;
    nd = 12;
    for (int i = 0; i < 30; i++) begin
      logic r, mis;
      logic [15:0] prim;
      r = 1'($urandom % 2);
      push(16'($urandom), 16'($urandom) & 16'hF0FF, r, {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom});
      nr++;
      nd++;
      wait_ring(nr, "R4 random ring");
      tick(int'($urandom % 4));
      if (!r) begin
        pulse_db(8'h01);
        wait_done(nd, "R5 random ack");
        chk(last_st == STAT_OK, "R5 random status", 64'(last_st), 64'(STAT_OK));
      end else begin
        mis  = ($urandom % 4) == 0;
        prim = 16'($urandom);
        rsp_mem[0] = {prim, 16'h0, 16'(cur_exp) ^ (mis ? 16'h0001 : 16'h0000), 16'h0};
        rsp_mem[1] = {$urandom, $urandom};
        if ($urandom % 2) pulse_db(8'h03);
        else begin
          pulse_db(8'h01);
          tick(int'($urandom % 3));
          pulse_db(8'h02);
        end
        wait_done(nd, "R6 random response");
        chk(last_st == (mis ? STAT_SEQ : prim), "R6 random status", 64'(last_st),
            64'(mis ? STAT_SEQ : prim));
      end
      chk(last_seq == 16'(cur_exp), "R4 done sequence", 64'(last_seq), 64'(cur_exp));
    end

    tick(2);
    chk(r1_viol == 0, "R1 single outstanding", 64'(r1_viol), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule